// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It combines two component predictors and lets a per-address selector decide which one to trust. The first component looks only at the outcomes of the most recent branches in the whole program. It keeps a shift register of those outcomes, and that history indexes a table of 2-bit saturating counters. The second component looks only at the past behaviour of the branch itself. A table indexed by branch address holds each branch's recent outcomes as a short pattern, and that pattern indexes a table of 3-bit saturating counters. A third table of 2-bit counters, indexed by branch address, records which component has been more reliable for that branch.

The lookup side is combinational. Given a fetch address, the block returns the final direction and both component directions, all read from the current table state. The caller keeps the two component directions with the branch. When the branch resolves, it presents them again on the update side together with the address and the real outcome. In that clock the block trains every table and shifts the outcome into both histories. The default configuration uses a 12-bit global history with 4096 global counters, 1024 local histories of 10 bits each, 1024 local counters and 4096 selector counters. Addresses are word aligned, and the table index is taken from the address bits just above the alignment bits, with no tag compare.

Top module: `tp_tourney_pred`

## Requirements
- R1: After reset every counter holds its weakly not-taken value, the selector favours the global component, and all histories are zero. A lookup at any address then returns not-taken on all three outputs.
- R2: The global component is a table of 2-bit saturating counters indexed by the global history. Its prediction is the counter's MSB (1 = taken). An update moves the counter at the current history by one toward the outcome, stopping at 0 and at 3.
- R3: On each update the global history shifts left by one, and the outcome (1 = taken) enters bit 0.
- R4: The local history table is indexed by the address bits directly above the alignment bits. On each update the entry of the updated branch shifts left by one and takes the outcome in bit 0. No other entry changes.
- R5: The local component is a table of 3-bit saturating counters indexed by the branch's local history. Its prediction is the counter's MSB. An update moves the counter at the branch's pre-update history by one toward the outcome, stopping at 0 and at 7.
- R6: The selector is a table of 2-bit counters indexed by the address bits directly above the alignment bits. MSB 1 selects the local component and MSB 0 selects the global component. The reset value 1 therefore selects global.
- R7: The selector entry is trained only when the supplied global and local predictions differ. It moves one step toward local (up) when the local prediction equals the outcome and one step toward global (down) otherwise, saturating at 0 and 3.
- R8: The final prediction equals the prediction of the component chosen by the selector entry of the lookup address.
- R9: With the update valid input low, the update inputs have no effect on any table or history.
- R10: Address bits below the alignment bits and above each index field do not affect a lookup or an update. Addresses that differ only there share entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Lookup branch address |
| lk_taken | output | 1 | Final predicted direction (1 = taken) |
| lk_glob_pred | output | 1 | Global component direction |
| lk_loc_pred | output | 1 | Local component direction |
| up_valid | input | 1 | Update strobe, one update per cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome (1 = taken) |
| up_glob_pred | input | 1 | Global direction returned at lookup |
| up_loc_pred | input | 1 | Local direction returned at lookup |

## Verification
The bench uses a small configuration and keeps a reference model of the tables, written directly from the requirements. After every update it sweeps lookups over every selector index. A branch that is always taken drives both counter kinds into saturation. A strictly alternating branch separates local-history indexing from global-history indexing, and a taken-taken-taken-not-taken loop branch is where the two components disagree and the selector must move. A long pseudo-random mix of several branches makes the histories alias, which exposes any wrong index or shift. Idle cycles with garbage on the update inputs, and lookups at addresses with altered alignment and high bits, show that those inputs leave the prediction unchanged.

// File: rtl/tp_pkg.sv
package tp_pkg;
    // which component the selector picks
    typedef enum logic {
        SEL_GLOBAL = 1'b0,
        SEL_LOCAL  = 1'b1
    } tp_sel_e;
endpackage

// File: rtl/tp_ctr_table.sv
// Table of saturating up/down counters. Two read ports: a lookup read that
// returns the counter MSB, and an internal read at the write index that
// feeds the read-modify-write update. Every entry resets to weakly not-taken.
module tp_ctr_table #(
    parameter int unsigned IDX_W = 12,
    parameter int unsigned CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_pred,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int unsigned DEPTH = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_WEAK = CTR_W'((1 << (CTR_W - 1)) - 1);

    logic [CTR_W-1:0] mem [DEPTH];
    logic [CTR_W-1:0] cur_val;
    logic [CTR_W-1:0] nxt_val;

    assign rd_pred = mem[rd_idx][CTR_W-1];

    always_comb begin
        cur_val = mem[wr_idx];
        nxt_val = cur_val;
        if (wr_up && (cur_val != CTR_MAX)) begin
            nxt_val = cur_val + 1'b1;
        end else if (!wr_up && (cur_val != '0)) begin
            nxt_val = cur_val - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= CTR_WEAK;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= nxt_val;
        end
    end
endmodule

// File: rtl/tp_hist_table.sv
// Per-branch outcome history table. Lookup read port plus a read of the
// entry being updated; the update shifts the new outcome into bit 0.
module tp_hist_table #(
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit,
    output logic [HIST_W-1:0] wr_cur_hist
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] mem [DEPTH];

    assign rd_hist     = mem[rd_idx];
    assign wr_cur_hist = mem[wr_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= {wr_cur_hist[HIST_W-2:0], wr_bit};
        end
    end
endmodule

// File: rtl/tp_ghist_reg.sv
// Global outcome shift register, newest outcome in bit 0.
module tp_ghist_reg #(
    parameter int unsigned HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '0;
        end else if (shift_en) begin
            hist <= {hist[HIST_W-2:0], shift_bit};
        end
    end
endmodule

// File: rtl/tp_tourney_pred.sv
module tp_tourney_pred
    import tp_pkg::*;
#(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned ALIGN_W   = 2,
    parameter int unsigned GHIST_W   = 12,
    parameter int unsigned LHIST_W   = 10,
    parameter int unsigned LHT_IDX_W = 10,
    parameter int unsigned CHO_IDX_W = 12,
    parameter int unsigned GCTR_W    = 2,
    parameter int unsigned LCTR_W    = 3,
    parameter int unsigned CHO_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_glob_pred,
    output logic            lk_loc_pred,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic            up_glob_pred,
    input  logic            up_loc_pred
);
    // address index fields sit directly above the alignment bits
    logic [LHT_IDX_W-1:0] lk_lht_idx, up_lht_idx;
    logic [CHO_IDX_W-1:0] lk_cho_idx, up_cho_idx;

    assign lk_lht_idx = lk_pc[ALIGN_W +: LHT_IDX_W];
    assign up_lht_idx = up_pc[ALIGN_W +: LHT_IDX_W];
    assign lk_cho_idx = lk_pc[ALIGN_W +: CHO_IDX_W];
    assign up_cho_idx = up_pc[ALIGN_W +: CHO_IDX_W];

    // bits outside the index fields are deliberately ignored
    logic unused_pc_bits;
    assign unused_pc_bits = ^{lk_pc, up_pc};

    // global component
    logic [GHIST_W-1:0] ghist;

    tp_ghist_reg #(.HIST_W(GHIST_W)) ghist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (up_valid),
        .shift_bit (up_taken),
        .hist      (ghist)
    );

    tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) glob_tbl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (ghist),
        .rd_pred (lk_glob_pred),
        .wr_en   (up_valid),
        .wr_idx  (ghist),
        .wr_up   (up_taken)
    );

    // local component: per-branch history, then pattern-indexed counters
    logic [LHIST_W-1:0] lk_lhist, up_lhist;

    tp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) lht_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_idx      (lk_lht_idx),
        .rd_hist     (lk_lhist),
        .wr_en       (up_valid),
        .wr_idx      (up_lht_idx),
        .wr_bit      (up_taken),
        .wr_cur_hist (up_lhist)
    );

    tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) loc_tbl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_lhist),
        .rd_pred (lk_loc_pred),
        .wr_en   (up_valid),
        .wr_idx  (up_lhist),
        .wr_up   (up_taken)
    );

    // selector: trains only on disagreement, up means toward local
    logic cho_wr_en;
    logic cho_toward_loc;
    logic cho_msb;
    tp_sel_e sel;

    assign cho_wr_en      = up_valid && (up_glob_pred != up_loc_pred);
    assign cho_toward_loc = (up_loc_pred == up_taken);

    tp_ctr_table #(.IDX_W(CHO_IDX_W), .CTR_W(CHO_W)) cho_tbl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_cho_idx),
        .rd_pred (cho_msb),
        .wr_en   (cho_wr_en),
        .wr_idx  (up_cho_idx),
        .wr_up   (cho_toward_loc)
    );

    always_comb begin
        sel = cho_msb ? SEL_LOCAL : SEL_GLOBAL;
        unique case (sel)
            SEL_LOCAL:  lk_taken = lk_loc_pred;
            SEL_GLOBAL: lk_taken = lk_glob_pred;
            default:    lk_taken = lk_glob_pred;
        endcase
    end
endmodule

// File: rtl/tp_tourney_chk.sv
module tp_tourney_chk #(
    parameter int unsigned GHIST_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               up_valid,
    input logic               up_taken,
    input logic               up_glob_pred,
    input logic               up_loc_pred,
    input logic               lk_taken,
    input logic               lk_glob_pred,
    input logic               lk_loc_pred,
    input logic               cho_wr_en,
    input logic [GHIST_W-1:0] ghist
);
    // R3
    ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> ghist == {$past(ghist[GHIST_W-2:0]), $past(up_taken)});

    // R9
    ghist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(ghist));

    // R7
    cho_agree_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_glob_pred == up_loc_pred) |-> !cho_wr_en);

    // R9
    cho_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |-> !cho_wr_en);

    // R8
    final_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_glob_pred == lk_loc_pred) |-> (lk_taken == lk_glob_pred));
endmodule

bind tp_tourney_pred tp_tourney_chk #(.GHIST_W(GHIST_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_valid     (up_valid),
    .up_taken     (up_taken),
    .up_glob_pred (up_glob_pred),
    .up_loc_pred  (up_loc_pred),
    .lk_taken     (lk_taken),
    .lk_glob_pred (lk_glob_pred),
    .lk_loc_pred  (lk_loc_pred),
    .cho_wr_en    (cho_wr_en),
    .ghist        (ghist)
);

// File: tb/tp_tourney_pred_tb_top.sv
module tp_tourney_pred_tb_top;
    localparam int PC_W = 16;
    localparam int ALIGN_W = 2;
    localparam int GHIST_W = 4;
    localparam int LHIST_W = 3;
    localparam int LHT_IDX_W = 2;
    localparam int CHO_IDX_W = 3;
    localparam int G_N = 1 << GHIST_W;
    localparam int LH_N = 1 << LHT_IDX_W;
    localparam int LC_N = 1 << LHIST_W;
    localparam int C_N = 1 << CHO_IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic lk_taken, lk_glob_pred, lk_loc_pred;
    logic up_valid = 1'b0;
    logic [PC_W-1:0] up_pc = '0;
    logic up_taken = 1'b0;
    logic up_glob_pred = 1'b0;
    logic up_loc_pred = 1'b0;

    always #2 clk = ~clk;

    tp_tourney_pred #(
        .PC_W(PC_W), .ALIGN_W(ALIGN_W), .GHIST_W(GHIST_W), .LHIST_W(LHIST_W),
        .LHT_IDX_W(LHT_IDX_W), .CHO_IDX_W(CHO_IDX_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_glob_pred(lk_glob_pred), .lk_loc_pred(lk_loc_pred),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken),
        .up_glob_pred(up_glob_pred), .up_loc_pred(up_loc_pred)
    );

    // reference model built from the requirements
    int gm [G_N];
    int lh [LH_N];
    int lc [LC_N];
    int cm [C_N];
    int gh;
    int n_chk = 0;
    int n_fail = 0;

    function automatic int m_lht(input int pc);
        return (pc >> ALIGN_W) % LH_N;
    endfunction
    function automatic int m_cho(input int pc);
        return (pc >> ALIGN_W) % C_N;
    endfunction
    function automatic int sat_step(input int v, input bit up, input int maxv);
        if (up) return (v < maxv) ? v + 1 : v;
        return (v > 0) ? v - 1 : v;
    endfunction
    function automatic bit m_glob();
        return gm[gh] >= 2;
    endfunction
    function automatic bit m_loc(input int pc);
        return lc[lh[m_lht(pc)]] >= 4;
    endfunction
    function automatic bit m_final(input int pc);
        return (cm[m_cho(pc)] >= 2) ? m_loc(pc) : m_glob();
    endfunction

    task automatic model_reset();
        for (int i = 0; i < G_N; i++) gm[i] = 1;
        for (int i = 0; i < LH_N; i++) lh[i] = 0;
        for (int i = 0; i < LC_N; i++) lc[i] = 3;
        for (int i = 0; i < C_N; i++) cm[i] = 1;
        gh = 0;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // lookup at pc, sampled 1 ns after a falling edge
    task automatic probe(input int pc, input int pc_drive, input string req);
        @(negedge clk);
        lk_pc = PC_W'(pc_drive);
        #1;
        check(lk_glob_pred == m_glob(), {req, " global"}, int'(lk_glob_pred), int'(m_glob()));
        check(lk_loc_pred == m_loc(pc), {req, " local"}, int'(lk_loc_pred), int'(m_loc(pc)));
        check(lk_taken == m_final(pc), {req, " final"}, int'(lk_taken), int'(m_final(pc)));
    endtask

    task automatic sweep(input string req);
        for (int i = 0; i < C_N; i++) probe(i << ALIGN_W, i << ALIGN_W, req);
    endtask

    task automatic do_update(input int pc, input bit t);
        bit gp, lp;
        int li;
        gp = m_glob();
        lp = m_loc(pc);
        @(negedge clk);
        up_pc = PC_W'(pc);
        up_taken = t;
        up_glob_pred = gp;
        up_loc_pred = lp;
        up_valid = 1'b1;
        @(posedge clk);
        gm[gh] = sat_step(gm[gh], t, 3);
        li = m_lht(pc);
        lc[lh[li]] = sat_step(lc[lh[li]], t, 7);
        lh[li] = ((lh[li] << 1) | int'(t)) % LC_N;
        if (gp != lp) cm[m_cho(pc)] = sat_step(cm[m_cho(pc)], lp == t, 3);
        gh = ((gh << 1) | int'(t)) % G_N;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, every address not-taken
        for (int i = 0; i < C_N; i++) begin
            @(negedge clk);
            lk_pc = PC_W'(i << ALIGN_W);
            #1;
            check(!lk_taken && !lk_glob_pred && !lk_loc_pred, "R1 reset lookup",
                  int'({lk_taken, lk_glob_pred, lk_loc_pred}), 0);
        end

        // R2 R5: always-taken branch saturates both counter kinds
        for (int k = 0; k < 10; k++) begin
            do_update(32'h4, 1'b1);
            sweep("R2 R5 saturating");
        end
        // R2 R5: then always not-taken, down to the floor
        for (int k = 0; k < 10; k++) begin
            do_update(32'h4, 1'b0);
            sweep("R2 R5 saturating down");
        end

        // R4: alternating branch on another local entry
        for (int k = 0; k < 12; k++) begin
            do_update(32'h8, k[0]);
            sweep("R4 local history");
        end

        // R6 R7: loop branch T T T N, components disagree at times
        for (int k = 0; k < 24; k++) begin
            do_update(32'h10, (k % 4) != 3);
            sweep("R6 R7 selector");
        end

        // R3 R8: pseudo-random mix over every selector index
        lfsr = 16'hACE1;
        for (int k = 0; k < 120; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_update(int'(lfsr[2:0]) << ALIGN_W, lfsr[5] | lfsr[7]);
            sweep("R3 R8 mixed");
        end

        // R9: garbage on update inputs with valid low
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            up_valid = 1'b0;
            up_pc = PC_W'(k * 12 + 4);
            up_taken = k[0];
            up_glob_pred = k[1];
            up_loc_pred = ~k[1];
            @(posedge clk);
            sweep("R9 idle update");
        end

        // R10: alignment and high address bits ignored on lookup
        for (int i = 0; i < C_N; i++) begin
            probe(i << ALIGN_W, (i << ALIGN_W) | 3 | 16'hF000, "R10 alias lookup");
        end
        // R10: update through an aliased address trains the same entries
        for (int k = 0; k < 8; k++) begin
            int base;
            base = (k % C_N) << ALIGN_W;
            do_update(base | 1 | 16'h8A00, k[1]);
            sweep("R10 alias update");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule